// File: doc/BRIEF.md
# Floating-Point NaN and Denormal Policy Stage

This stage wraps an external floating-point arithmetic datapath and decides what reaches the destination register. It inspects the source operands of each operation, in single or double precision. It flushes denormal operands before they enter the datapath. It then chooses the final result from three candidates: the datapath's raw result, a fixed generated quiet NaN, or a sign-only move of the first operand. It also decides whether the destination is written and whether an invalid-operation exception is signalled.

The NaN polarity used here is the reverse of the common convention. A NaN whose fraction MSB is set is signalling, and one with that bit clear is quiet. The three sign-only moves (copy, absolute value, negate) are carried out inside the stage, and no NaN or denormal rule applies to them. The operand outputs are combinational from the inputs, so the external datapath can return its raw result in the same cycle. Result, write enable and exception are registered once.

Top module: `fp_special_policy`

## Requirements
- R1: A value-generating operation (op_kind 2'b00) that has a used signalling NaN operand and inv_en=0 produces the generated quiet NaN with res_we=1 and no exception. The generated quiet NaN is 32'h7FBFFFFF in single precision and 64'h7FF7FFFFFFFFFFFF in double precision.
- R2: If the same case occurs with inv_en=1, inv_pulse=1 and res_we=0.
- R3: A value-generating operation with a used quiet NaN operand and no used signalling NaN produces the generated quiet NaN with res_we=1 and inv_pulse=0, whatever inv_en is.
- R4: An operand is a NaN when its exponent is all ones and its fraction is non-zero. It is signalling when the fraction MSB (bit 22 single, bit 51 double) is 1, and quiet when that bit is 0.
- R5: Copy (2'b01), absolute value (2'b10) and negate (2'b11) act on src_a only. They pass it through, clear its sign bit, or invert its sign bit (bit 31 single, bit 63 double). They apply no NaN or denormal rule and always give res_we=1 and inv_pulse=0.
- R6: For a value-generating operation with flush_en=1, a denormal src_a or src_b (exponent zero, fraction non-zero) appears on dp_a/dp_b as a zero with its sign kept. With flush_en=0, or for a move operation, the operand passes through unchanged.
- R7: For a value-generating operation with no NaN operand, res is raw_res. If raw_res is denormal and flush_en=1, res is a zero with raw_res's sign instead.
- R8: res_valid, res_we, res and inv_pulse appear exactly one clock after in_valid and last one cycle. Synchronous active-high rst clears res_valid, res_we and inv_pulse.
- R9: With dbl=0, only bits [31:0] of src_a, src_b and raw_res are used. Bits [63:32] of res, dp_a and dp_b are driven to zero.
- R10: With two_src=0, src_b takes no part in the NaN checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 00 arithmetic, 01 copy, 10 absolute, 11 negate |
| dbl | input | 1 | 1 = double precision, 0 = single |
| two_src | input | 1 | 1 = src_b is an operand |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| raw_res | input | 64 | Result from the external datapath |
| inv_en | input | 1 | Invalid-operation exception enable |
| flush_en | input | 1 | Denormal flush-to-zero enable |
| dp_a | output | 64 | Flushed first operand to the datapath |
| dp_b | output | 64 | Flushed second operand to the datapath |
| res_valid | output | 1 | Registered result valid |
| res | output | 64 | Final result |
| res_we | output | 1 | Destination write enable |
| inv_pulse | output | 1 | Invalid-operation exception pulse |

## Verification
The assertions assume that rst is held for at least one clock before any in_valid. They also assume that raw_res arrives in the same cycle as its operands, so it is a combinational reply to dp_a/dp_b. The bench drives every input on the falling edge, keeps each operation valid for exactly one cycle, and supplies raw_res alongside the operands. Whenever the bench raises in_valid, op_kind, dbl and two_src are always defined values.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
   typedef enum logic [1:0] {
      FPP_ARITH = 2'b00,
      FPP_COPY  = 2'b01,
      FPP_ABS   = 2'b10,
      FPP_NEG   = 2'b11
   } fpp_op_e;

   localparam logic [31:0] FPP_GEN_QNAN_S = 32'h7FBF_FFFF;
   localparam logic [63:0] FPP_GEN_QNAN_D = 64'h7FF7_FFFF_FFFF_FFFF;
endpackage

// File: rtl/fpp_classify.sv
module fpp_classify #(
   parameter int S_EXP  = 8,
   parameter int S_FRAC = 23,
   parameter int D_EXP  = 11,
   parameter int D_FRAC = 52,
   localparam int SW    = 1 + S_EXP + S_FRAC,
   localparam int W     = 1 + D_EXP + D_FRAC
) (
   input  logic [W-1:0] val,
   input  logic         dbl,
   input  logic         flush,
   output logic         is_nan,
   output logic         is_snan,
   output logic         is_denorm,
   output logic [W-1:0] fixed
);
   logic [S_EXP-1:0]  s_exp;
   logic [S_FRAC-1:0] s_frac;
   logic [D_EXP-1:0]  d_exp;
   logic [D_FRAC-1:0] d_frac;

   if (SW >= W) begin : g_bad_width
      $error("single format must be narrower than double format");
   end

   assign s_exp  = val[S_FRAC +: S_EXP];
   assign s_frac = val[S_FRAC-1:0];
   assign d_exp  = val[D_FRAC +: D_EXP];
   assign d_frac = val[D_FRAC-1:0];

   always_comb begin
      if (dbl) begin
         is_nan    = (&d_exp) && (|d_frac);
         is_snan   = is_nan && d_frac[D_FRAC-1];
         is_denorm = (d_exp == '0) && (|d_frac);
         fixed     = (flush && is_denorm) ? {val[W-1], {(W-1){1'b0}}} : val;
      end else begin
         is_nan    = (&s_exp) && (|s_frac);
         is_snan   = is_nan && s_frac[S_FRAC-1];
         is_denorm = (s_exp == '0) && (|s_frac);
         fixed     = (flush && is_denorm) ?
                     {{(W-SW){1'b0}}, val[SW-1], {(SW-1){1'b0}}} :
                     {{(W-SW){1'b0}}, val[SW-1:0]};
      end
   end
endmodule

// File: rtl/fpp_move.sv
module fpp_move #(
   parameter int SW = 32,
   parameter int W  = 64
) (
   input  logic [1:0]   op,
   input  logic         dbl,
   input  logic [W-1:0] val,
   output logic [W-1:0] moved
);
   import fpp_pkg::*;

   if (SW >= W) begin : g_bad_width
      $error("single width must be below double width");
   end

   always_comb begin
      moved = dbl ? val : {{(W-SW){1'b0}}, val[SW-1:0]};
      unique case (fpp_op_e'(op))
         FPP_ABS: begin
            if (dbl) moved[W-1] = 1'b0;
            else     moved[SW-1] = 1'b0;
         end
         FPP_NEG: begin
            if (dbl) moved[W-1] = ~val[W-1];
            else     moved[SW-1] = ~val[SW-1];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/fp_special_policy.sv
module fp_special_policy #(
   parameter int S_EXP  = 8,
   parameter int S_FRAC = 23,
   parameter int D_EXP  = 11,
   parameter int D_FRAC = 52,
   parameter int N_SRC  = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        in_valid,
   input  logic [1:0]  op_kind,
   input  logic        dbl,
   input  logic        two_src,
   input  logic [63:0] src_a,
   input  logic [63:0] src_b,
   input  logic [63:0] raw_res,
   input  logic        inv_en,
   input  logic        flush_en,
   output logic [63:0] dp_a,
   output logic [63:0] dp_b,
   output logic        res_valid,
   output logic [63:0] res,
   output logic        res_we,
   output logic        inv_pulse
);
   import fpp_pkg::*;

   localparam int SW = 1 + S_EXP + S_FRAC;
   localparam int W  = 1 + D_EXP + D_FRAC;

   if (W != 64 || SW != 32) begin : g_bad_fmt
      $error("formats must be 32 and 64 bits wide");
   end
   if (N_SRC != 2) begin : g_bad_src
      $error("exactly two source ports are supported");
   end

   logic [N_SRC-1:0][W-1:0] src, src_fixed;
   logic [N_SRC-1:0]        used, nan_v, snan_v, den_v;
   logic                    arith, any_snan, any_nan;
   logic                    r_nan, r_snan, r_den;
   logic [W-1:0]            r_fixed, moved, qnan, nxt_res;
   logic                    nxt_we, nxt_inv, dbl_q;

   assign arith   = (fpp_op_e'(op_kind) == FPP_ARITH);
   assign src[0]  = src_a;
   assign src[1]  = src_b;
   assign used[0] = 1'b1;
   assign used[1] = two_src;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      fpp_classify #(.S_EXP(S_EXP), .S_FRAC(S_FRAC), .D_EXP(D_EXP), .D_FRAC(D_FRAC)) u_cls (
         .val(src[i]), .dbl(dbl), .flush(flush_en && arith),
         .is_nan(nan_v[i]), .is_snan(snan_v[i]), .is_denorm(den_v[i]),
         .fixed(src_fixed[i])
      );
   end

   assign dp_a     = src_fixed[0];
   assign dp_b     = src_fixed[1];
   assign any_snan = |(snan_v & used);
   assign any_nan  = |(nan_v & used);

   fpp_classify #(.S_EXP(S_EXP), .S_FRAC(S_FRAC), .D_EXP(D_EXP), .D_FRAC(D_FRAC)) u_rcls (
      .val(raw_res), .dbl(dbl), .flush(flush_en && arith),
      .is_nan(r_nan), .is_snan(r_snan), .is_denorm(r_den), .fixed(r_fixed)
   );

   fpp_move #(.SW(SW), .W(W)) u_move (
      .op(op_kind), .dbl(dbl), .val(src_a), .moved(moved)
   );

   assign qnan = dbl ? FPP_GEN_QNAN_D : {{(W-SW){1'b0}}, FPP_GEN_QNAN_S};

   always_comb begin
      nxt_res = r_fixed;
      nxt_we  = 1'b1;
      nxt_inv = 1'b0;
      if (!arith) begin
         nxt_res = moved;
      end else if (any_snan) begin
         nxt_res = qnan;
         nxt_we  = !inv_en;
         nxt_inv = inv_en;
      end else if (any_nan) begin
         nxt_res = qnan;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_we    <= 1'b0;
         inv_pulse <= 1'b0;
      end else begin
         res_valid <= in_valid;
         res_we    <= in_valid && nxt_we;
         inv_pulse <= in_valid && nxt_inv;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         res   <= nxt_res;
         dbl_q <= dbl;
      end
   end

   // R2
   trap_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      inv_pulse |-> (!res_we && res_valid));
   // R8
   one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!res_valid && !res_we && !inv_pulse));
   // R5
   move_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !arith) |=> (!inv_pulse && res_we));
   // R3
   quiet_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && arith && any_nan && !any_snan) |=> (!inv_pulse && res_we));
   // R9
   single_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !dbl_q) |-> (res[63:32] == 32'h0));
   // R6
   operand_flush_chk: assert property (@(posedge clk) disable iff (rst)
      (!arith && dbl) |-> (dp_a == src_a && dp_b == src_b));
endmodule

// File: tb/sim_fp_special_policy.sv
`timescale 1ns/1ps
module sim_fp_special_policy;
   typedef struct packed {
      logic [1:0]  op;
      logic        dbl;
      logic        two;
      logic        inv;
      logic        fl;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] raw;
      logic [63:0] eres;
      logic        ewe;
      logic        einv;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      // R1 R4 single sNaN in b, trap off
      '{2'b00,1'b0,1'b1,1'b0,1'b0,64'h3F800000,64'h7FC00001,64'h12345678,64'h7FBFFFFF,1'b1,1'b0},
      // R2 single sNaN, trap on
      '{2'b00,1'b0,1'b1,1'b1,1'b0,64'h3F800000,64'h7FC00001,64'h12345678,64'h7FBFFFFF,1'b0,1'b1},
      // R3 R4 single qNaN, trap on
      '{2'b00,1'b0,1'b1,1'b1,1'b0,64'h3F800000,64'h7F800001,64'h12345678,64'h7FBFFFFF,1'b1,1'b0},
      // R1 R4 double sNaN in a
      '{2'b00,1'b1,1'b0,1'b0,1'b0,64'h7FF8000000000001,64'h0,64'h1,64'h7FF7FFFFFFFFFFFF,1'b1,1'b0},
      // R3 double qNaN, trap on
      '{2'b00,1'b1,1'b0,1'b1,1'b0,64'h7FF0000000000001,64'h0,64'h1,64'h7FF7FFFFFFFFFFFF,1'b1,1'b0},
      // R2 double sNaN in b
      '{2'b00,1'b1,1'b1,1'b1,1'b0,64'h3FF0000000000000,64'hFFF8000000000002,64'h1,64'h7FF7FFFFFFFFFFFF,1'b0,1'b1},
      // R7 plain result
      '{2'b00,1'b0,1'b1,1'b1,1'b1,64'h3F800000,64'h3F800000,64'h40000000,64'h40000000,1'b1,1'b0},
      // R7 denormal result flushed, sign kept
      '{2'b00,1'b0,1'b1,1'b0,1'b1,64'h3F800000,64'h3F800000,64'h80000005,64'h80000000,1'b1,1'b0},
      // R7 denormal result kept
      '{2'b00,1'b0,1'b1,1'b0,1'b0,64'h3F800000,64'h3F800000,64'h80000005,64'h80000005,1'b1,1'b0},
      // R5 copy of sNaN
      '{2'b01,1'b0,1'b0,1'b1,1'b1,64'hFFC00001,64'h0,64'h0,64'hFFC00001,1'b1,1'b0},
      // R5 abs of sNaN
      '{2'b10,1'b0,1'b0,1'b1,1'b1,64'hFFC00001,64'h0,64'h0,64'h7FC00001,1'b1,1'b0},
      // R5 negate single
      '{2'b11,1'b0,1'b0,1'b0,1'b0,64'h3F800000,64'h0,64'h0,64'hBF800000,1'b1,1'b0},
      // R5 negate double sNaN
      '{2'b11,1'b1,1'b0,1'b1,1'b0,64'h7FF8000000000001,64'h0,64'h0,64'hFFF8000000000001,1'b1,1'b0},
      // R10 unused b is sNaN
      '{2'b00,1'b0,1'b0,1'b1,1'b0,64'h3F800000,64'h7FC00001,64'h3F800000,64'h3F800000,1'b1,1'b0},
      // R9 upper bits ignored in single
      '{2'b00,1'b0,1'b0,1'b0,1'b0,64'hDEADBEEF3F800000,64'h0,64'hFFFFFFFF40000000,64'h0000000040000000,1'b1,1'b0}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [1:0]  op_kind;
   logic        dbl, two_src, inv_en, flush_en;
   logic [63:0] src_a, src_b, raw_res;
   logic [63:0] dp_a, dp_b, res;
   logic        res_valid, res_we, inv_pulse;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   fp_special_policy u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_kind(op_kind), .dbl(dbl),
      .two_src(two_src), .src_a(src_a), .src_b(src_b), .raw_res(raw_res),
      .inv_en(inv_en), .flush_en(flush_en), .dp_a(dp_a), .dp_b(dp_b),
      .res_valid(res_valid), .res(res), .res_we(res_we), .inv_pulse(inv_pulse)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic vld);
      in_valid = vld; op_kind = v.op; dbl = v.dbl; two_src = v.two;
      inv_en = v.inv; flush_en = v.fl; src_a = v.a; src_b = v.b; raw_res = v.raw;
   endtask

   initial begin
      rst = 1'b1;
      drive('0, 1'b0);
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 reset valid", {63'b0, res_valid}, 64'd0);
      chk("R8 reset we",    {63'b0, res_we},    64'd0);
      chk("R8 reset inv",   {63'b0, inv_pulse}, 64'd0);
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i], 1'b1);
         @(negedge clk);
         chk($sformatf("R1-vec%0d res", i), res, VECS[i].eres);
         chk($sformatf("R2-vec%0d we", i), {63'b0, res_we}, {63'b0, VECS[i].ewe});
         chk($sformatf("R3-vec%0d inv", i), {63'b0, inv_pulse}, {63'b0, VECS[i].einv});
         chk($sformatf("R8-vec%0d valid", i), {63'b0, res_valid}, 64'd1);
      end

      // R8 pulse lasts one cycle
      drive(VECS[1], 1'b0);
      @(negedge clk);
      chk("R8 idle valid", {63'b0, res_valid}, 64'd0);
      chk("R8 inv one cycle", {63'b0, inv_pulse}, 64'd0);

      // R6 operand flush, single, sign kept
      drive('{2'b00,1'b0,1'b1,1'b0,1'b1,64'h80000005,64'h00000003,64'h0,64'h0,1'b0,1'b0}, 1'b0);
      #1;
      chk("R6 dp_a flush", dp_a, 64'h80000000);
      chk("R6 dp_b flush", dp_b, 64'h00000000);
      flush_en = 1'b0;
      #1;
      chk("R6 dp_a no flush", dp_a, 64'h80000005);
      // R6 move op leaves operand alone
      flush_en = 1'b1; op_kind = 2'b01;
      #1;
      chk("R6 move no flush", dp_a, 64'h80000005);
      // R6 double denormal
      op_kind = 2'b00; dbl = 1'b1; src_b = 64'h8000000000000007;
      #1;
      chk("R6 double dp_b", dp_b, 64'h8000000000000000);
      // R9 single dp upper zero
      dbl = 1'b0; src_a = 64'hABCD00003F800000;
      #1;
      chk("R9 dp_a upper", dp_a, 64'h000000003F800000);

      // R8 reset mid-stream clears outputs
      drive(VECS[1], 1'b1);
      rst = 1'b1;
      @(negedge clk);
      chk("R8 reset clears inv", {63'b0, inv_pulse}, 64'd0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule